// File: doc/BRIEF.md
# Debug Breakpoint Hit Detector

This block watches four debug address slots on behalf of a processor core. Each slot holds an address and has an enable pair, a kind field and a length field in a shared control word. Every clock the block compares the instruction pointer against the slots set up as instruction breakpoints. It also takes a per-slot hit flag from the memory pipeline for the slots set up as data watchpoints. From these it works out which slots fired.

When a slot fires, the block rebuilds the debug status word. The four low status bits are replaced by the set of slots that fired in that cycle, whether or not each slot was enabled. The rest of the word is carried over. The new word is committed only when an enabled slot fired or the core requests a forced update. A commit raises a one-cycle write strobe, and an enabled hit also raises a debug-exception request. The address and control registers and the status word are loaded through a small configuration write port.

The length code of each slot is driven out to the data address comparators, which sit outside this block.

Top module: `dbg_bp_detect`

## Requirements
- R1: A slot of kind 00 (instruction) fires when its address register equals `ip_i`. It ignores its `wp_hit_i` bit.
- R2: A slot of kind 01 (data write) or 11 (data read/write) fires when its `wp_hit_i` bit is high. It ignores `ip_i`. Kind 10 (I/O) never fires.
- R3: In the control word, slot N has its enable pair at bits [2N+1:2N], its kind at [17+4N:16+4N] and its length at [19+4N:18+4N]. The slot is enabled when either bit of the enable pair is set.
- R4: A rebuilt status word keeps the previous status bits [31:4]. It has bit N set exactly for each slot N that fired in the evaluated cycle, enabled or not.
- R5: The status word is replaced by the rebuilt word only when an enabled slot fired or `force_upd_i` was high. In that case `stat_wr_o` is high for the one following cycle. Otherwise the status word and `stat_wr_o` hold at their previous value and at 0.
- R6: `dbg_exc_o` is high in the cycle after an evaluation in which at least one enabled slot fired, and low otherwise.
- R7: After reset, the address registers are 0, the status word reads 0xFFFF0FF0, the control word is 0x00000400, and both `stat_wr_o` and `dbg_exc_o` are low. The block leaves reset on the third rising clock edge after `rst_n` goes high.
- R8: A configuration write selects its target with `cfg_sel_i`: 0 to 3 pick an address slot, 4 the control word, 5 the status word. A control write stores the data ORed with 0x00000400, and a status write stores the data ORed with 0xFFFF0FF0. Selects 6 and 7 change nothing. A written value takes part in evaluation from the next cycle on.
- R9: A status write in the same cycle as a commit wins. The status word takes the written value and `stat_wr_o` stays low, while `dbg_exc_o` still follows R6.
- R10: `wp_len_o[2N+1:2N]` equals slot N's length field. Codes 0, 1, 2 and 3 stand for 1, 2, 8 and 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 3 | Configuration write target select |
| cfg_wdata_i | input | 32 | Configuration write data |
| ip_i | input | 32 | Current instruction pointer |
| wp_hit_i | input | 4 | Per-slot data watchpoint hit flags |
| force_upd_i | input | 1 | Commit the rebuilt status even without an enabled hit |
| stat_o | output | 32 | Debug status word |
| stat_wr_o | output | 1 | Status word was just committed from a hit evaluation |
| dbg_exc_o | output | 1 | Debug exception request |
| wp_len_o | output | 8 | Per-slot length codes for the watchpoint comparators |

## Verification
The directed patterns cover several cases. A disabled instruction slot hit, with and without the force input, shows that recording and committing are separate. An enabled hit shows that the stale low bits are cleared. Data-kind slots are driven with their hit flag and with the instruction pointer, and the I/O kind is driven with a hit flag, which separates the three kind decodes. Two slots firing together test the mask merge. A status write during an enabled hit tests the priority rule. Writes to the unused selects, followed by a hit on slot 0, show that these writes left the slot's address and the control word untouched. Enabling a slot through only the upper bit of its pair tests the enable decode. A long random phase then compares status, strobe, exception and length codes against a behavioural model on every clock.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

  localparam int unsigned NSLOT = 4;
  localparam int unsigned REGW  = 32;
  localparam int unsigned SELW  = 3;
  localparam int unsigned LENW  = 2;

  localparam logic [SELW-1:0] SEL_CTRL = SELW'(4);
  localparam logic [SELW-1:0] SEL_STAT = SELW'(5);

  typedef enum logic [1:0] {
    BK_EXEC = 2'b00,
    BK_WR   = 2'b01,
    BK_IO   = 2'b10,
    BK_RW   = 2'b11
  } bk_kind_e;

endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
  import dbg_bp_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDX  = 0
) (
  input  logic [REGW-1:0] ctrl_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] ip_i,
  input  logic            wp_hit_i,
  output logic            match_o,
  output logic            armed_o,
  output logic [LENW-1:0] len_o
);

  localparam int unsigned EN_LSB   = 2 * IDX;
  localparam int unsigned KIND_LSB = 16 + 4 * IDX;
  localparam int unsigned LEN_LSB  = 18 + 4 * IDX;

  bk_kind_e kind;

  always_comb begin
    kind    = bk_kind_e'(ctrl_i[KIND_LSB +: 2]);
    armed_o = |ctrl_i[EN_LSB +: 2];
    len_o   = ctrl_i[LEN_LSB +: LENW];
    unique case (kind)
      BK_EXEC:      match_o = (addr_i == ip_i);
      BK_WR, BK_RW: match_o = wp_hit_i;
      default:      match_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
  import dbg_bp_pkg::*;
#(
  parameter int unsigned    XLEN      = 32,
  parameter logic [REGW-1:0] CTRL_ONES = 32'h0000_0400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [SELW-1:0]       sel_i,
  input  logic [XLEN-1:0]       wdata_i,
  output logic [NSLOT*XLEN-1:0] addr_o,
  output logic [REGW-1:0]       ctrl_o
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_addr
    logic            ld;
    logic [XLEN-1:0] nxt;
    logic [XLEN-1:0] q;

    always_comb begin
      ld  = we_i && (sel_i == SELW'(g));
      nxt = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (ld) q <= nxt;
    end

    assign addr_o[g*XLEN +: XLEN] = q;
  end

  logic            ctrl_ld;
  logic [REGW-1:0] ctrl_nxt;
  logic [REGW-1:0] ctrl_q;

  always_comb begin
    ctrl_ld  = we_i && (sel_i == SEL_CTRL);
    ctrl_nxt = wdata_i[REGW-1:0] | CTRL_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_ONES;
    else if (ctrl_ld) ctrl_q <= ctrl_nxt;
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dbg_bp_commit.sv
module dbg_bp_commit
  import dbg_bp_pkg::*;
#(
  parameter logic [REGW-1:0] STAT_ONES = 32'hFFFF_0FF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] match_i,
  input  logic [NSLOT-1:0] armed_i,
  input  logic             force_i,
  input  logic             swr_i,
  input  logic [REGW-1:0]  swdata_i,
  output logic [REGW-1:0]  stat_o,
  output logic             wr_o,
  output logic             exc_o
);

  logic            en_hit;
  logic            upd;
  logic            stat_ld;
  logic [REGW-1:0] fresh;
  logic [REGW-1:0] stat_nxt;
  logic            wr_nxt;
  logic            exc_nxt;
  logic [REGW-1:0] stat_q;
  logic            wr_q;
  logic            exc_q;

  always_comb begin
    en_hit   = |(match_i & armed_i);
    upd      = en_hit | force_i;
    fresh    = {stat_q[REGW-1:NSLOT], match_i};
    stat_ld  = swr_i | upd;
    stat_nxt = swr_i ? (swdata_i | STAT_ONES) : fresh;
    wr_nxt   = upd & ~swr_i;
    exc_nxt  = en_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_ONES;
      wr_q   <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      if (stat_ld) stat_q <= stat_nxt;
      wr_q  <= wr_nxt;
      exc_q <= exc_nxt;
    end
  end

  assign stat_o = stat_q;
  assign wr_o   = wr_q;
  assign exc_o  = exc_q;

endmodule

// File: rtl/dbg_bp_detect.sv
module dbg_bp_detect
  import dbg_bp_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [REGW-1:0] STAT_ONES = 32'hFFFF_0FF0,
  parameter logic [REGW-1:0] CTRL_ONES = 32'h0000_0400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we_i,
  input  logic [SELW-1:0]       cfg_sel_i,
  input  logic [XLEN-1:0]       cfg_wdata_i,
  input  logic [XLEN-1:0]       ip_i,
  input  logic [NSLOT-1:0]      wp_hit_i,
  input  logic                  force_upd_i,
  output logic [REGW-1:0]       stat_o,
  output logic                  stat_wr_o,
  output logic                  dbg_exc_o,
  output logic [NSLOT*LENW-1:0] wp_len_o
);

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [NSLOT*XLEN-1:0] addr_all;
  logic [REGW-1:0]       ctrl;
  logic [NSLOT-1:0]      match;
  logic [NSLOT-1:0]      armed;
  logic                  stat_sw;

  dbg_bp_regs #(.XLEN(XLEN), .CTRL_ONES(CTRL_ONES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .addr_o  (addr_all),
    .ctrl_o  (ctrl)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dbg_bp_slot #(.XLEN(XLEN), .IDX(s)) u_slot (
      .ctrl_i   (ctrl),
      .addr_i   (addr_all[s*XLEN +: XLEN]),
      .ip_i     (ip_i),
      .wp_hit_i (wp_hit_i[s]),
      .match_o  (match[s]),
      .armed_o  (armed[s]),
      .len_o    (wp_len_o[s*LENW +: LENW])
    );
  end

  assign stat_sw = cfg_we_i && (cfg_sel_i == SEL_STAT);

  dbg_bp_commit #(.STAT_ONES(STAT_ONES)) u_commit (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .match_i  (match),
    .armed_i  (armed),
    .force_i  (force_upd_i),
    .swr_i    (stat_sw),
    .swdata_i (cfg_wdata_i[REGW-1:0]),
    .stat_o   (stat_o),
    .wr_o     (stat_wr_o),
    .exc_o    (dbg_exc_o)
  );

endmodule

// File: rtl/dbg_bp_detect_chk.sv
module dbg_bp_detect_chk
  import dbg_bp_pkg::*;
#(
  parameter logic [REGW-1:0] STAT_ONES = 32'hFFFF_0FF0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we_i,
  input logic [SELW-1:0] cfg_sel_i,
  input logic            force_upd_i,
  input logic [REGW-1:0] stat_o,
  input logic            stat_wr_o,
  input logic            dbg_exc_o
);

  logic sw_now;
  assign sw_now = cfg_we_i && (cfg_sel_i == SEL_STAT);

  p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |-> (dbg_exc_o || $past(force_upd_i)));

  p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_o && !$past(sw_now)) |-> $stable(stat_o));

  p_exc_commits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc_o && !$past(sw_now)) |-> stat_wr_o);

  p_upper_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |-> (stat_o[REGW-1:NSLOT] == $past(stat_o[REGW-1:NSLOT])));

  p_fixed_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o & STAT_ONES) == STAT_ONES));

  p_sw_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_now |=> !stat_wr_o);

endmodule

bind dbg_bp_detect dbg_bp_detect_chk #(.STAT_ONES(STAT_ONES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we_i    (cfg_we_i),
  .cfg_sel_i   (cfg_sel_i),
  .force_upd_i (force_upd_i),
  .stat_o      (stat_o),
  .stat_wr_o   (stat_wr_o),
  .dbg_exc_o   (dbg_exc_o)
);

// File: tb/dbg_bp_detect_bench.sv
module dbg_bp_detect_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] S_ONES     = 32'hFFFF_0FF0;
  localparam logic [31:0] C_ONES     = 32'h0000_0400;
  localparam logic [31:0] IDLE_IP    = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = 3'd0;
  logic [31:0] cfg_wdata_i = 32'd0;
  logic [31:0] ip_i = IDLE_IP;
  logic [3:0]  wp_hit_i = 4'd0;
  logic        force_upd_i = 1'b0;
  logic [31:0] stat_o;
  logic        stat_wr_o;
  logic        dbg_exc_o;
  logic [7:0]  wp_len_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bp_detect u_dbg_bp_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .ip_i        (ip_i),
    .wp_hit_i    (wp_hit_i),
    .force_upd_i (force_upd_i),
    .stat_o      (stat_o),
    .stat_wr_o   (stat_wr_o),
    .dbg_exc_o   (dbg_exc_o),
    .wp_len_o    (wp_len_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl, m_stat;
  logic        m_wr, m_exc;
  int          rel;
  logic [3:0]  fired;
  logic        any_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_addr[i] = 32'd0;
      m_ctrl = C_ONES; m_stat = S_ONES; m_wr = 1'b0; m_exc = 1'b0; rel = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      fired = 4'd0; any_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
        int kind;
        kind = int'(m_ctrl[16+4*i +: 2]);
        if ((kind == 0 && m_addr[i] == ip_i) || ((kind % 2) == 1 && wp_hit_i[i])) begin
          fired[i] = 1'b1;
          if (m_ctrl[2*i +: 2] != 2'b00) any_en = 1'b1;
        end
      end
      m_exc = any_en;
      if (cfg_we_i && cfg_sel_i == 3'd5) begin
        m_stat = cfg_wdata_i | S_ONES; m_wr = 1'b0;
      end else if (any_en || force_upd_i) begin
        m_stat = {m_stat[31:4], fired}; m_wr = 1'b1;
      end else begin
        m_wr = 1'b0;
      end
      if (cfg_we_i && cfg_sel_i < 3'd4) m_addr[cfg_sel_i[1:0]] = cfg_wdata_i;
      if (cfg_we_i && cfg_sel_i == 3'd4) m_ctrl = cfg_wdata_i | C_ONES;
    end
  end

  function automatic logic [7:0] exp_len(input logic [31:0] c);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) r[2*i +: 2] = c[18+4*i +: 2];
    return r;
  endfunction

  always @(negedge clk) begin
    chk("R4 status vs model", stat_o, m_stat);
    chk("R5 strobe vs model", {31'd0, stat_wr_o}, {31'd0, m_wr});
    chk("R6 exception vs model", {31'd0, dbg_exc_o}, {31'd0, m_exc});
    chk("R10 length vs model", {24'd0, wp_len_o}, {24'd0, exp_len(m_ctrl)});
  end

  task automatic cyc_w(input logic [31:0] ip, input logic [3:0] wh, input logic frc,
                       input logic we, input logic [2:0] sel, input logic [31:0] d);
    ip_i = ip; wp_hit_i = wh; force_upd_i = frc;
    cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we_i = 1'b0; force_upd_i = 1'b0; wp_hit_i = 4'd0; ip_i = IDLE_IP;
  endtask

  task automatic cyc(input logic [31:0] ip, input logic [3:0] wh, input logic frc);
    cyc_w(ip, wh, frc, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wcfg(input logic [2:0] sel, input logic [31:0] d);
    cyc_w(IDLE_IP, 4'd0, 1'b0, 1'b1, sel, d);
  endtask

  task automatic expect3(input string tag, input logic [31:0] st, input logic wr, input logic ex);
    chk({tag, " status"}, stat_o, st);
    chk({tag, " strobe"}, {31'd0, stat_wr_o}, {31'd0, wr});
    chk({tag, " exception"}, {31'd0, dbg_exc_o}, {31'd0, ex});
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7 reset state
    expect3("R7 reset", 32'hFFFF_0FF0, 1'b0, 1'b0);
    chk("R7 reset length", {24'd0, wp_len_o}, 32'd0);

    wcfg(3'd0, 32'h0000_1000);
    wcfg(3'd1, 32'h0000_2000);
    wcfg(3'd4, 32'h0000_0001);
    chk("R10 zero lengths", {24'd0, wp_len_o}, 32'd0);

    cyc(32'h2000, 4'd0, 1'b0);
    expect3("R5 disabled hit not committed", 32'hFFFF_0FF0, 1'b0, 1'b0);
    cyc(32'h2000, 4'd0, 1'b1);
    expect3("R4 forced commit records disabled slot", 32'hFFFF_0FF2, 1'b1, 1'b0);
    cyc(32'h1000, 4'd0, 1'b0);
    expect3("R1 instruction hit clears stale bits", 32'hFFFF_0FF1, 1'b1, 1'b1);
    cyc(IDLE_IP, 4'd0, 1'b0);
    expect3("R5 strobe lasts one cycle", 32'hFFFF_0FF1, 1'b0, 1'b0);

    wcfg(3'd4, 32'h0900_0021);
    chk("R10 slot2 length code", {24'd0, wp_len_o}, 32'h20);
    cyc(IDLE_IP, 4'b0100, 1'b0);
    expect3("R2 write watchpoint hit", 32'hFFFF_0FF4, 1'b1, 1'b1);
    cyc(IDLE_IP, 4'b0001, 1'b0);
    expect3("R2 instruction slot ignores hit flag", 32'hFFFF_0FF4, 1'b0, 1'b0);

    wcfg(3'd4, 32'h2900_0061);
    cyc(IDLE_IP, 4'b1000, 1'b0);
    expect3("R2 io kind never fires", 32'hFFFF_0FF4, 1'b0, 1'b0);
    wcfg(3'd4, 32'h3900_0061);
    cyc(32'h1000, 4'b1000, 1'b0);
    expect3("R4 two slots merged", 32'hFFFF_0FF9, 1'b1, 1'b1);

    cyc_w(32'h1000, 4'd0, 1'b0, 1'b1, 3'd5, 32'h0000_A003);
    expect3("R9 status write wins", 32'hFFFF_AFF3, 1'b0, 1'b1);

    cyc_w(IDLE_IP, 4'd0, 1'b0, 1'b1, 3'd6, 32'h0000_0000);
    cyc_w(IDLE_IP, 4'd0, 1'b0, 1'b1, 3'd7, 32'h0000_0000);
    expect3("R8 unused selects", 32'hFFFF_AFF3, 1'b0, 1'b0);
    cyc(32'h1000, 4'd0, 1'b0);
    expect3("R8 slot0 intact after unused selects", 32'hFFFF_AFF1, 1'b1, 1'b1);

    wcfg(3'd4, 32'h0000_0000);
    cyc(32'h1000, 4'd0, 1'b0);
    expect3("R3 cleared enables", 32'hFFFF_AFF1, 1'b0, 1'b0);
    wcfg(3'd4, 32'h0000_0002);
    cyc(32'h1000, 4'd0, 1'b0);
    expect3("R3 upper enable bit", 32'hFFFF_AFF1, 1'b1, 1'b1);

    wcfg(3'd0, 32'h0000_3000);
    cyc(32'h1000, 4'd0, 1'b0);
    expect3("R8 old address gone", 32'hFFFF_AFF1, 1'b0, 1'b0);
    cyc(32'h3000, 4'd0, 1'b0);
    expect3("R8 new address used", 32'hFFFF_AFF1, 1'b1, 1'b1);

    // random phase, compared against the model every clock
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ipv;
      logic [31:0] d;
      logic [2:0]  s;
      case ($urandom_range(0, 4))
        0: ipv = 32'h1000;
        1: ipv = 32'h2000;
        2: ipv = 32'h3000;
        3: ipv = 32'h0;
        default: ipv = IDLE_IP;
      endcase
      s = 3'($urandom_range(0, 7));
      d = (s < 3'd4) ? (32'h1000 * 32'($urandom_range(0, 3))) : $urandom;
      cyc_w(ipv, 4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 4) == 0), s, d);
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule